// File: doc/BRIEF.md
# Two-Level Interrupt Enable Controller

This block collects interrupt events from a small set of core sources and from a group of peripheral sources, one of which is the overflow of a built-in free-running timer. Every event latches a flag, and the flags hold whatever the enables are. The block raises a single interrupt request toward a simple processor core. The request is allowed only when a matching source enable and flag are both set and the global enable, which software can see, is on. A second, hidden enable must also be on. Sources in the peripheral group additionally need the peripheral-group enable.

Software reaches the block through three small registers chosen by a select field. The core control register carries the global enable, the peripheral-group enable, the core source enables and the core flags. The peripheral enable register and the peripheral flag register hold one bit per peripheral source. The core reports two events back. When it accepts a request, the global enable and the hidden enable both drop, which keeps the handler from being interrupted again. When it executes its return-from-interrupt step, both enables come back on. The block also drives a constant vector address for the handler entry.

Top module: `irq_gate_ctrl`

## Requirements
- R1: A flag is set on the clock edge after its event, whether or not any enable is set. It stays set until a register write clears it. Core flags sit in core control bits [NC-1:0] with NC=(REG_W-2)/2. Peripheral flag bit k+1 takes `periph_evt[k]`, and peripheral flag bit 0 takes the timer overflow.
- R2: When a write clears a flag in the same cycle as a new event for that flag, the flag stays 1.
- R3: Register layout. Select 0 is core control, with bit REG_W-1 as the global enable, bit REG_W-2 as the peripheral-group enable, bits [2*NC-1:NC] as the core source enables and bits [NC-1:0] as the core flags. Select 1 is the peripheral enable register. Select 2 is the peripheral flag register. Select 3 reads as zero and ignores writes. The read data is combinational.
- R4: `irq_req` is combinational from the register state. It is 1 exactly when the global enable and the hidden enable are both 1 and either some core source has its enable and flag set, or the peripheral-group enable is 1 and some peripheral source has its enable and flag set.
- R5: If the peripheral-group enable is 0, a peripheral source with both its enable and its flag set never raises `irq_req`.
- R6: A one-cycle `irq_ack` clears both the global enable and the hidden enable on that edge. If software sets the global enable again before the return step, `irq_req` stays 0.
- R7: A one-cycle `irq_ret` sets both the global enable and the hidden enable on that edge. If `irq_ack` comes in the same cycle, `irq_ack` wins.
- R8: The timer counts up by one on each cycle that `tmr_tick` is 1. When it wraps from all ones to 0, it sets peripheral flag bit 0.
- R9: `irq_vector` is always 0x004, counted in instruction words.
- R10: After reset, all enables, all flags and the timer are 0, and the hidden enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select (0 core control, 1 peripheral enable, 2 peripheral flag) |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected register |
| core_evt | input | NC | Event pulses of the core sources |
| periph_evt | input | REG_W-1 | Event pulses of peripheral sources 1 and up |
| tmr_tick | input | 1 | Count enable of the timer |
| irq_ack | input | 1 | Core accepted the interrupt |
| irq_ret | input | 1 | Core executed return-from-interrupt |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | VEC_W | Handler entry address |

## Verification
The bench builds the block with REG_W=8, which gives three core sources and eight peripheral sources. It also builds it with TMR_W=8, so the timer wraps after 256 ticks and the overflow flag, including the exact tick that sets it, can be reached in a short run. With these values the bench can also drive the interleaving of acceptance, a software write of the global enable and the return step within a few cycles. At the same sizes it drives an event on the same edge as a clearing write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SEL_CORE  = 2'd0,
    SEL_PEN   = 2'd1,
    SEL_PFLAG = 2'd2,
    SEL_NONE  = 2'd3
  } irqc_sel_e;

  // Next value of one sticky flag: a write replaces it, an event forces it high.
  function automatic logic flag_next(input logic cur, input logic wr,
                                     input logic wdata, input logic evt);
    return (wr ? wdata : cur) | evt;
  endfunction

  // Any source with both enable and flag set (vectors zero-extended to 32).
  function automatic logic any_pending(input logic [31:0] en, input logic [31:0] flg);
    return |(en & flg);
  endfunction

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);
  import irqc_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= flag_next(q[i], wr, wdata[i], evt[i]);
    end
  end
endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/irqc_gate_ctrl.sv
module irqc_gate_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_gie,
  input  logic wdata_gie,
  input  logic ack,
  input  logic ret,
  output logic gie,
  output logic hidden_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie       <= 1'b0;
      hidden_en <= 1'b1;
    end else if (ack) begin
      gie       <= 1'b0;
      hidden_en <= 1'b0;
    end else if (ret) begin
      gie       <= 1'b1;
      hidden_en <= 1'b1;
    end else if (wr_gie) begin
      gie       <= wdata_gie;
    end
  end
endmodule

// File: rtl/irqc_wrap_timer.sv
module irqc_wrap_timer #(
  parameter int TMR_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic wrap
);
  localparam logic [TMR_W-1:0] CNT_MAX = '1;
  logic [TMR_W-1:0] cnt;

  assign wrap = tick && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl #(
  parameter int          REG_W    = 8,
  parameter int          TMR_W    = 16,
  parameter int          VEC_W    = 13,
  parameter int unsigned VEC_ADDR = 4,
  localparam int         NC       = (REG_W - 2) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NC-1:0]    core_evt,
  input  logic [REG_W-2:0] periph_evt,
  input  logic             tmr_tick,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector
);
  import irqc_pkg::*;

  localparam int GIE_BIT  = REG_W - 1;
  localparam int PEIE_BIT = REG_W - 2;

  irqc_sel_e sel;
  assign sel = irqc_sel_e'(reg_sel);

  // Named internal events
  logic wr_core, wr_pen, wr_pflag;
  assign wr_core  = reg_wr && (sel == SEL_CORE);
  assign wr_pen   = reg_wr && (sel == SEL_PEN);
  assign wr_pflag = reg_wr && (sel == SEL_PFLAG);

  logic [NC-1:0]    core_en, core_flag;
  logic [0:0]       peie;
  logic [REG_W-1:0] per_en, per_flag;
  logic             gie, hidden_en, tmr_wrap;
  logic             core_pend, per_pend;

  irqc_enable_reg #(.W(NC)) u_core_en (
    .clk(clk), .rst_n(rst_n), .wr(wr_core),
    .wdata(reg_wdata[2*NC-1:NC]), .q(core_en));

  irqc_enable_reg #(.W(1)) u_peie (
    .clk(clk), .rst_n(rst_n), .wr(wr_core),
    .wdata(reg_wdata[PEIE_BIT]), .q(peie));

  irqc_enable_reg #(.W(REG_W)) u_per_en (
    .clk(clk), .rst_n(rst_n), .wr(wr_pen),
    .wdata(reg_wdata), .q(per_en));

  irqc_flag_bank #(.W(NC)) u_core_flag (
    .clk(clk), .rst_n(rst_n), .wr(wr_core),
    .wdata(reg_wdata[NC-1:0]), .evt(core_evt), .q(core_flag));

  irqc_flag_bank #(.W(REG_W)) u_per_flag (
    .clk(clk), .rst_n(rst_n), .wr(wr_pflag),
    .wdata(reg_wdata), .evt({periph_evt, tmr_wrap}), .q(per_flag));

  irqc_gate_ctrl u_gate (
    .clk(clk), .rst_n(rst_n), .wr_gie(wr_core), .wdata_gie(reg_wdata[GIE_BIT]),
    .ack(irq_ack), .ret(irq_ret), .gie(gie), .hidden_en(hidden_en));

  irqc_wrap_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .wrap(tmr_wrap));

  assign core_pend = any_pending(32'(core_en), 32'(core_flag));
  assign per_pend  = any_pending(32'(per_en), 32'(per_flag));
  assign irq_req   = gie && hidden_en && (core_pend || (peie[0] && per_pend));

  assign irq_vector = VEC_W'(VEC_ADDR);

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CORE: begin
        reg_rdata[GIE_BIT]     = gie;
        reg_rdata[PEIE_BIT]    = peie[0];
        reg_rdata[2*NC-1:NC]   = core_en;
        reg_rdata[NC-1:0]      = core_flag;
      end
      SEL_PEN:   reg_rdata = per_en;
      SEL_PFLAG: reg_rdata = per_flag;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_req,
  input logic          irq_ack,
  input logic          irq_ret,
  input logic          gie,
  input logic          hidden_en,
  input logic          peie,
  input logic          core_pend,
  input logic          wr_core,
  input logic [NC-1:0] core_flag,
  input logic          tmr_wrap,
  input logic          tflag
);
  // R1: core flags never drop without a write to the core control register
  assert_flag_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_core |=> ((core_flag & $past(core_flag)) == $past(core_flag)));

  // R4: a request needs both enable levels
  assert_req_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie && hidden_en));

  // R5: without the group enable, only a core source can request
  assert_no_periph_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !peie) |-> core_pend);

  // R6: acceptance drops both enables
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!gie && !hidden_en && !irq_req));

  // R7: return restores both enables
  assert_ret_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack) |=> (gie && hidden_en));

  // R8: a timer wrap leaves the overflow flag set
  assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> tflag);
endmodule

bind irq_gate_ctrl irqc_checker #(.NC(NC)) u_irqc_checker (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
  .irq_ret(irq_ret), .gie(gie), .hidden_en(hidden_en), .peie(peie[0]),
  .core_pend(core_pend), .wr_core(wr_core), .core_flag(core_flag),
  .tmr_wrap(tmr_wrap), .tflag(per_flag[0]));

// File: tb/tb_irq_gate_ctrl.sv
`timescale 1ns/1ps
module tb_irq_gate_ctrl;
  localparam int REG_W = 8;
  localparam int TMR_W = 8;
  localparam int VEC_W = 13;
  localparam int NC    = (REG_W - 2) / 2;
  localparam int TMAX  = (1 << TMR_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       reg_sel = '0;
  logic             reg_wr = 1'b0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic [NC-1:0]    core_evt = '0;
  logic [REG_W-2:0] periph_evt = '0;
  logic             tmr_tick = 1'b0;
  logic             irq_ack = 1'b0;
  logic             irq_ret = 1'b0;
  logic             irq_req;
  logic [VEC_W-1:0] irq_vector;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_gate_ctrl #(.REG_W(REG_W), .TMR_W(TMR_W), .VEC_W(VEC_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_evt(core_evt),
    .periph_evt(periph_evt), .tmr_tick(tmr_tick), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .irq_req(irq_req), .irq_vector(irq_vector));

  // ---------------- behavioural reference model ----------------
  bit m_gie, m_hid, m_peie;
  bit m_cen[NC];
  bit m_cfl[NC];
  bit m_pen[REG_W];
  bit m_pfl[REG_W];
  int m_tcnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gie = 0; m_hid = 1; m_peie = 0; m_tcnt = 0;
      foreach (m_cen[i]) begin m_cen[i] = 0; m_cfl[i] = 0; end
      foreach (m_pen[i]) begin m_pen[i] = 0; m_pfl[i] = 0; end
    end else begin
      bit wrap;
      wrap = tmr_tick && (m_tcnt == TMAX);
      if (tmr_tick) m_tcnt = (m_tcnt == TMAX) ? 0 : m_tcnt + 1;
      if (reg_wr && reg_sel == 2'd0) begin
        m_peie = reg_wdata[REG_W-2];
        for (int i = 0; i < NC; i++) begin
          m_cen[i] = reg_wdata[NC + i];
          m_cfl[i] = reg_wdata[i];
        end
      end
      if (reg_wr && reg_sel == 2'd1)
        for (int i = 0; i < REG_W; i++) m_pen[i] = reg_wdata[i];
      if (reg_wr && reg_sel == 2'd2)
        for (int i = 0; i < REG_W; i++) m_pfl[i] = reg_wdata[i];
      for (int i = 0; i < NC; i++) if (core_evt[i]) m_cfl[i] = 1;
      for (int i = 1; i < REG_W; i++) if (periph_evt[i-1]) m_pfl[i] = 1;
      if (wrap) m_pfl[0] = 1;
      if (irq_ack) begin m_gie = 0; m_hid = 0; end
      else if (irq_ret) begin m_gie = 1; m_hid = 1; end
      else if (reg_wr && reg_sel == 2'd0) m_gie = reg_wdata[REG_W-1];
    end
  end

  function automatic bit m_req();
    bit c = 0, p = 0;
    for (int i = 0; i < NC; i++) c |= m_cen[i] & m_cfl[i];
    for (int i = 0; i < REG_W; i++) p |= m_pen[i] & m_pfl[i];
    return m_gie && m_hid && (c || (m_peie && p));
  endfunction

  function automatic int m_read(input int sel);
    int v = 0;
    case (sel)
      0: begin
        v = (int'(m_gie) << (REG_W-1)) | (int'(m_peie) << (REG_W-2));
        for (int i = 0; i < NC; i++) v |= (int'(m_cen[i]) << (NC+i)) | int'(m_cfl[i]) << i;
      end
      1: for (int i = 0; i < REG_W; i++) v |= int'(m_pen[i]) << i;
      2: for (int i = 0; i < REG_W; i++) v |= int'(m_pfl[i]) << i;
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R3, R4)
  always @(negedge clk) if (rst_n) begin
    chk("R4 model irq_req", int'(irq_req), int'(m_req()));
    chk("R3 model rdata", int'(reg_rdata), m_read(int'(reg_sel)));
  end

  task automatic cyc();
    @(posedge clk); #1;
    reg_wr = 0; core_evt = '0; periph_evt = '0; irq_ack = 0; irq_ret = 0; tmr_tick = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [REG_W-1:0] d);
    reg_sel = s; reg_wr = 1; reg_wdata = d; cyc();
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] s, input int exp);
    reg_sel = s; #0.5;
    chk(tag, int'(reg_rdata), exp);
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10 reset state
    rd_chk("R10 core reg after reset", 2'd0, 0);
    rd_chk("R10 pflag after reset", 2'd2, 0);
    chk("R10 irq_req after reset", int'(irq_req), 0);
    chk("R9 vector", int'(irq_vector), 4);

    // R1 flag latches with every enable off
    core_evt = 3'b001; cyc();
    rd_chk("R1 flag latched while disabled", 2'd0, 8'h01);
    chk("R1 no request while disabled", int'(irq_req), 0);
    cyc();
    rd_chk("R1 flag stays set", 2'd0, 8'h01);

    // R3/R4 global enable bit 7, source enable bit 3
    wr(2'd0, 8'h89);
    rd_chk("R3 core reg layout", 2'd0, 8'h89);
    chk("R4 request with enables set", int'(irq_req), 1);

    // R6 accept, then software sets global enable in handler
    irq_ack = 1; cyc();
    chk("R6 request dropped after accept", int'(irq_req), 0);
    rd_chk("R6 global enable cleared", 2'd0, 8'h09);
    wr(2'd0, 8'h89);
    chk("R6 hidden enable still blocks", int'(irq_req), 0);
    rd_chk("R6 global enable written", 2'd0, 8'h89);

    // R7 return restores
    wr(2'd0, 8'h09);
    irq_ret = 1; cyc();
    rd_chk("R7 global enable restored", 2'd0, 8'h89);
    chk("R7 request resumes", int'(irq_req), 1);

    // R7 ack wins over ret
    irq_ack = 1; irq_ret = 1; cyc();
    chk("R7 ack beats ret", int'(irq_req), 0);
    irq_ret = 1; cyc();

    // R1 clear by write
    wr(2'd0, 8'h88);
    rd_chk("R1 flag cleared by write", 2'd0, 8'h88);
    chk("R1 no request after clear", int'(irq_req), 0);

    // R2 clear with simultaneous event
    core_evt = 3'b001; reg_sel = 2'd0; reg_wr = 1; reg_wdata = 8'h88; cyc();
    rd_chk("R2 event beats clearing write", 2'd0, 8'h89);
    wr(2'd0, 8'h80);
    // R1 peripheral event line
    periph_evt = 7'b0000100; cyc();
    rd_chk("R1 periph flag bit 3 latched", 2'd2, 8'h08);
    wr(2'd2, 8'h00);

    // R8 timer wrap, R5 group enable gate
    wr(2'd1, 8'h01);
    for (int i = 0; i < TMAX; i++) begin tmr_tick = 1; cyc(); end
    rd_chk("R8 no flag before wrap", 2'd2, 0);
    tmr_tick = 1; cyc();
    rd_chk("R8 overflow flag set on wrap", 2'd2, 8'h01);
    chk("R5 no request without group enable", int'(irq_req), 0);
    wr(2'd0, 8'hC0);
    chk("R5 request with group enable", int'(irq_req), 1);

    // R3 unused select
    wr(2'd3, 8'hFF);
    rd_chk("R3 select 3 reads zero", 2'd3, 0);
    rd_chk("R3 select 3 write ignored", 2'd1, 8'h01);
    repeat (2) cyc();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule